// File: doc/BRIEF.md
# Interrupt Delegation and Target-Level Selector

This block sits beside a processor's trap-entry logic. Every cycle it looks at all pending interrupt sources and decides whether one of them should be taken now, and which privilege level (machine, supervisor or user) receives the trap. Each source's level comes from two chained delegation masks. The first mask hands a source from machine to supervisor level. The second hands it on from supervisor to user level. Whether the chosen source may interrupt the running code depends on how its target level compares with the current level. A higher target always interrupts. An equal target interrupts only when that level's global enable is set. A lower target never interrupts, and the source waits.

There are three kinds of source: software, timer and external. Each kind has `LINES` request lines. With the default of three lines, the lines within a kind are interchangeable. Their index implies no privilege, and delegation alone decides where each line goes. The three global enables are read from one status word.

When a source is taken, the block raises a one-cycle strobe together with the target level and the cause index. It then waits for an acknowledge from the trap-entry logic before it issues another strobe.

Top module: `irq_target_sel`

## Requirements
- R1: Level encoding: 0 is user, 1 is supervisor, 3 is machine. A source whose machine-delegation bit is 0 targets machine level. If that bit is 1 and its supervisor-delegation bit is 0, it targets supervisor level. If both bits are 1, it targets user level. The reported target level is never 2.
- R2: A qualified source is taken when its target level is above the current level. At an equal level it is taken only if the global enable `gie_i[level]` is set. It is never taken when its target is below the current level.
- R3: A source is considered only when its request bit and its own enable bit are both 1.
- R4: Source bit positions are: software lines at bits 0..LINES-1, timer lines at LINES..2*LINES-1, external lines at 2*LINES..3*LINES-1, with line n at offset n. `cause_o` is the bit position of the source that was taken.
- R5: When several sources may be taken, a higher target level wins first. Within a level, external beats software, and software beats timer. Within a kind, the higher line index wins.
- R6: `take_o` rises in the cycle after the qualifying inputs are sampled at a clock edge. It lasts exactly one cycle, and `tgt_lvl_o` and `cause_o` are valid while it is high.
- R7: After a strobe, no further strobe is issued until `ack_i` is seen. A new strobe can appear at the earliest two cycles after the acknowledge. An `ack_i` that arrives while nothing is outstanding has no effect.
- R8: A source that cannot be taken is not dropped. While its request stays asserted, it is taken as soon as the level or enable conditions allow.
- R9: During synchronous active-low reset, `take_o`, `tgt_lvl_o` and `cause_o` are all 0.
- R10: Current-privilege code 2 is treated as machine level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req_i | input | LINES | Software interrupt requests |
| tmr_req_i | input | LINES | Timer interrupt requests |
| ext_req_i | input | LINES | External interrupt requests |
| src_en_i | input | 3*LINES | Per-source enable bits (R4 layout) |
| deleg_m_i | input | 3*LINES | Machine-to-supervisor delegation mask |
| deleg_s_i | input | 3*LINES | Supervisor-to-user delegation mask |
| priv_i | input | 2 | Current privilege level |
| gie_i | input | 4 | Global enables from the status word; bit 0 user, bit 1 supervisor, bit 3 machine, bit 2 unused |
| ack_i | input | 1 | Trap entry has accepted the last strobe |
| take_o | output | 1 | One-cycle take strobe |
| tgt_lvl_o | output | 2 | Target level of the trap |
| cause_o | output | clog2(3*LINES) | Bit position of the source taken |

## Verification
The bench sweeps every combination of current level, both delegation bits, the three global enables and the source enable for one external line. It compares each result with a model of the level-comparison rule. A design that checked the global enable for a higher target would lose interrupts, and one that ignored the enable at an equal level would preempt code that had masked interrupts. Directed cases cover the following:
- Competing sources at different levels and of different kinds. A wrong priority order shows up as a wrong cause.
- A request that is blocked and then allowed by a change of privilege. A design that drops blocked requests never fires.
- A request held high with no acknowledge. A design without suppression re-fires every cycle.
- An acknowledge that arrives while idle.
- The reserved privilege code.

// File: rtl/irq_sel_pkg.sv
// Package: shared level encoding and source-kind numbering for the
// interrupt target selector. Assumes the 0/1/3 privilege encoding.
package irq_sel_pkg;

    typedef enum logic [1:0] {
        LVL_U   = 2'd0,
        LVL_S   = 2'd1,
        LVL_RSV = 2'd2,
        LVL_M   = 2'd3
    } lvl_e;

    // Kind slots in the source vector, lowest bits first.
    localparam int KIND_SW  = 0;
    localparam int KIND_TMR = 1;
    localparam int KIND_EXT = 2;
    localparam int NUM_KIND = 3;

    // Map the reserved privilege code onto machine level.
    function automatic lvl_e norm_lvl(input logic [1:0] raw);
        return (raw == 2'd2) ? LVL_M : lvl_e'(raw);
    endfunction

endpackage

// File: rtl/irq_route.sv
// Module: per-source routing. For each source it works out the target level
// from the two delegation masks and whether the source may be taken at the
// current level. Purely combinational; assumes cur_i is already normalised.
module irq_route
    import irq_sel_pkg::*;
#(
    parameter int SRC_W = 9
) (
    input  logic [SRC_W-1:0]      pend_i,
    input  logic [SRC_W-1:0]      en_i,
    input  logic [SRC_W-1:0]      dm_i,
    input  logic [SRC_W-1:0]      ds_i,
    input  lvl_e                  cur_i,
    input  logic [3:0]            gie_i,
    output logic [SRC_W-1:0]      ok_o,
    output logic [SRC_W-1:0][1:0] tgt_o
);

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        lvl_e tgt;
        logic lvl_ok;

        // Pick the target level from the chained delegation bits.
        always_comb begin
            if (!dm_i[i])      tgt = LVL_M;
            else if (!ds_i[i]) tgt = LVL_S;
            else               tgt = LVL_U;
        end

        // Higher target preempts; equal needs the global enable; lower waits.
        always_comb begin
            if (tgt > cur_i)       lvl_ok = 1'b1;
            else if (tgt == cur_i) lvl_ok = gie_i[tgt];
            else                   lvl_ok = 1'b0;
        end

        assign ok_o[i]  = pend_i[i] & en_i[i] & lvl_ok;
        assign tgt_o[i] = tgt;
    end

endmodule

// File: rtl/irq_prio.sv
// Module: fixed-priority pick among takeable sources. Order: target level
// M > S > U, then kind external > software > timer, then higher line index.
// Combinational; later matches in the scan override earlier ones.
module irq_prio
    import irq_sel_pkg::*;
#(
    parameter int LINES   = 3,
    parameter int SRC_W   = NUM_KIND * LINES,
    parameter int CAUSE_W = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0]      ok_i,
    input  logic [SRC_W-1:0][1:0] tgt_i,
    output logic                  found_o,
    output logic [CAUSE_W-1:0]    idx_o,
    output logic [1:0]            lvl_o
);

    // Scan from lowest to highest priority so the last hit is the winner.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = LVL_U;
        for (int lv = 0; lv < 4; lv++) begin
            for (int r = 0; r < NUM_KIND; r++) begin
                for (int ln = 0; ln < LINES; ln++) begin
                    int kind;
                    int idx;
                    kind = (r == 0) ? KIND_TMR : ((r == 1) ? KIND_SW : KIND_EXT);
                    idx  = kind * LINES + ln;
                    if (ok_i[idx] && (tgt_i[idx] == 2'(lv))) begin
                        found_o = 1'b1;
                        idx_o   = CAUSE_W'(idx);
                        lvl_o   = 2'(lv);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_handshake.sv
// Module: issues the one-cycle take strobe and holds off further strobes
// until the trap-entry logic acknowledges. Target and cause are latched at
// issue and held. Synchronous active-low reset.
module irq_handshake #(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               found_i,
    input  logic [CAUSE_W-1:0] idx_i,
    input  logic [1:0]         lvl_i,
    input  logic               ack_i,
    output logic               take_o,
    output logic [1:0]         lvl_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic busy_q;
    logic issue;

    assign issue = found_i & ~busy_q;

    // Track an outstanding strobe until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_q <= 1'b0;
        else if (issue)            busy_q <= 1'b1;
        else if (busy_q && ack_i)  busy_q <= 1'b0;
    end

    // Register the strobe and latch its level and cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            lvl_o   <= 2'd0;
            cause_o <= '0;
        end else begin
            take_o <= issue;
            if (issue) begin
                lvl_o   <= lvl_i;
                cause_o <= idx_i;
            end
        end
    end

endmodule

// File: rtl/irq_target_sel.sv
// Module: top of the interrupt target selector. Assembles the source vector
// (software, timer, external, LINES each), routes every source to its level,
// picks a winner and hands it to the strobe/acknowledge stage.
// Assumes the delegation masks and enables are stable CSR outputs.
module irq_target_sel
    import irq_sel_pkg::*;
#(
    parameter int LINES   = 3,
    parameter int SRC_W   = NUM_KIND * LINES,
    parameter int CAUSE_W = $clog2(SRC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   sw_req_i,
    input  logic [LINES-1:0]   tmr_req_i,
    input  logic [LINES-1:0]   ext_req_i,
    input  logic [SRC_W-1:0]   src_en_i,
    input  logic [SRC_W-1:0]   deleg_m_i,
    input  logic [SRC_W-1:0]   deleg_s_i,
    input  logic [1:0]         priv_i,
    input  logic [3:0]         gie_i,
    input  logic               ack_i,
    output logic               take_o,
    output logic [1:0]         tgt_lvl_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic [SRC_W-1:0]      pend;
    logic [SRC_W-1:0]      ok;
    logic [SRC_W-1:0][1:0] tgt;
    logic                  found;
    logic [CAUSE_W-1:0]    sel_idx;
    logic [1:0]            sel_lvl;
    lvl_e                  cur;

    assign pend = {ext_req_i, tmr_req_i, sw_req_i};
    assign cur  = norm_lvl(priv_i);

    irq_route #(.SRC_W(SRC_W)) u_route (
        .pend_i (pend),
        .en_i   (src_en_i),
        .dm_i   (deleg_m_i),
        .ds_i   (deleg_s_i),
        .cur_i  (cur),
        .gie_i  (gie_i),
        .ok_o   (ok),
        .tgt_o  (tgt)
    );

    irq_prio #(.LINES(LINES), .SRC_W(SRC_W), .CAUSE_W(CAUSE_W)) u_prio (
        .ok_i    (ok),
        .tgt_i   (tgt),
        .found_o (found),
        .idx_o   (sel_idx),
        .lvl_o   (sel_lvl)
    );

    irq_handshake #(.CAUSE_W(CAUSE_W)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .found_i (found),
        .idx_i   (sel_idx),
        .lvl_i   (sel_lvl),
        .ack_i   (ack_i),
        .take_o  (take_o),
        .lvl_o   (tgt_lvl_o),
        .cause_o (cause_o)
    );

endmodule

// File: rtl/irq_target_sel_chk.sv
// Checker: temporal properties of the selector, observed at its ports.
module irq_target_sel_chk #(
    parameter int LINES   = 3,
    parameter int SRC_W   = 3 * LINES,
    parameter int CAUSE_W = $clog2(SRC_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINES-1:0]   sw_req_i,
    input logic [LINES-1:0]   tmr_req_i,
    input logic [LINES-1:0]   ext_req_i,
    input logic [SRC_W-1:0]   src_en_i,
    input logic [SRC_W-1:0]   deleg_m_i,
    input logic [1:0]         priv_i,
    input logic               take_o,
    input logic [1:0]         tgt_lvl_o,
    input logic [CAUSE_W-1:0] cause_o
);

    logic [SRC_W-1:0] qual_q;
    logic [SRC_W-1:0] dm_q;
    logic [1:0]       cur_q;

    // Remember last cycle's qualified sources, delegation and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= '0;
            dm_q   <= '0;
            cur_q  <= 2'd3;
        end else begin
            qual_q <= {ext_req_i, tmr_req_i, sw_req_i} & src_en_i;
            dm_q   <= deleg_m_i;
            cur_q  <= (priv_i == 2'd2) ? 2'd3 : priv_i;
        end
    end

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_no_demote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (tgt_lvl_o >= cur_q));

    assert_src_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> qual_q[cause_o]);

    assert_lvl_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (tgt_lvl_o != 2'd2));

    assert_mach_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !dm_q[cause_o]) |-> (tgt_lvl_o == 2'd3));

endmodule

bind irq_target_sel irq_target_sel_chk #(.LINES(LINES), .SRC_W(SRC_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_req_i  (sw_req_i),
    .tmr_req_i (tmr_req_i),
    .ext_req_i (ext_req_i),
    .src_en_i  (src_en_i),
    .deleg_m_i (deleg_m_i),
    .priv_i    (priv_i),
    .take_o    (take_o),
    .tgt_lvl_o (tgt_lvl_o),
    .cause_o   (cause_o)
);

// File: tb/irq_target_sel_tb.sv
// Bench: exhaustive sweep of one external line plus directed priority,
// hold, suppression and reserved-level cases. Reference computed here.
module irq_target_sel_tb;

    localparam int LINES = 3;
    localparam int SRC_W = 9;
    localparam int CW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] sw_req = '0, tmr_req = '0, ext_req = '0;
    logic [SRC_W-1:0] src_en = '0, deleg_m = '0, deleg_s = '0;
    logic [1:0]       priv = 2'd0;
    logic [3:0]       gie = 4'd0;
    logic             ack = 1'b0;
    logic             take;
    logic [1:0]       tgt_lvl;
    logic [CW-1:0]    cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_target_sel #(.LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_req_i(sw_req), .tmr_req_i(tmr_req), .ext_req_i(ext_req),
        .src_en_i(src_en), .deleg_m_i(deleg_m), .deleg_s_i(deleg_s),
        .priv_i(priv), .gie_i(gie), .ack_i(ack),
        .take_o(take), .tgt_lvl_o(tgt_lvl), .cause_o(cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Clear requests and acknowledge so nothing stays outstanding.
    task automatic drain();
        sw_req = '0; tmr_req = '0; ext_req = '0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 take", int'(take), 0);
        chk("R9 lvl", int'(tgt_lvl), 0);
        chk("R9 cause", int'(cause), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: sweep external line 0 (bit 6)
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 4; d++) begin
                for (int g = 0; g < 8; g++) begin
                    for (int e = 0; e < 2; e++) begin
                        int cur, tl, ok;
                        deleg_m = '0; deleg_s = '0; src_en = '0;
                        deleg_m[6] = d[0];
                        deleg_s[6] = d[1];
                        src_en[6]  = e[0];
                        gie  = {g[2], 1'b1, g[1], g[0]};
                        priv = 2'(p);
                        ext_req = 3'b001;
                        cur = (p == 2) ? 3 : p;
                        tl  = !d[0] ? 3 : (!d[1] ? 1 : 0);
                        if (tl > cur)       ok = 1;
                        else if (tl == cur) ok = int'(gie[tl]);
                        else                ok = 0;
                        if (e == 0) ok = 0;
                        @(negedge clk);
                        chk("R2 take", int'(take), ok);
                        if (ok == 1) begin
                            chk("R1 level", int'(tgt_lvl), tl);
                            chk("R4 cause", int'(cause), 6);
                        end
                        drain();
                    end
                end
            end
        end

        // R5: higher level wins over kind (ext->S vs sw line2 ->M)
        src_en = '1; deleg_m = '0; deleg_s = '0; gie = 4'd0; priv = 2'd0;
        deleg_m[6] = 1'b1;
        ext_req = 3'b001; sw_req = 3'b100;
        @(negedge clk);
        chk("R5 level first", int'(cause), 2);
        chk("R5 level first lvl", int'(tgt_lvl), 3);
        drain();

        // R5: kind order at machine level
        deleg_m = '0;
        sw_req = 3'b001; tmr_req = 3'b001; ext_req = 3'b010;
        @(negedge clk);
        chk("R5 ext first", int'(cause), 7);
        drain();
        sw_req = 3'b001; tmr_req = 3'b001;
        @(negedge clk);
        chk("R5 sw over tmr", int'(cause), 0);
        drain();
        ext_req = 3'b101;
        @(negedge clk);
        chk("R5 line order", int'(cause), 8);
        drain();

        // R8: blocked while in machine level, taken after drop to user
        deleg_m = '0; deleg_m[6] = 1'b1; gie = 4'hF; priv = 2'd3;
        ext_req = 3'b001;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 held", int'(take), 0);
        end
        priv = 2'd0;
        @(negedge clk);
        chk("R8 taken later", int'(take), 1);
        chk("R8 level", int'(tgt_lvl), 1);
        drain();

        // R6 R7: single pulse, suppression until ack
        deleg_m = '0; priv = 2'd0; ext_req = 3'b001;
        @(negedge clk);
        chk("R6 first strobe", int'(take), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 suppressed", int'(take), 0);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 ack cycle", int'(take), 0);
        @(negedge clk);
        chk("R7 reissue", int'(take), 1);
        drain();

        // R7: ack while idle has no effect
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        ext_req = 3'b001;
        @(negedge clk);
        chk("R7 idle ack", int'(take), 1);
        @(negedge clk);
        chk("R7 idle ack pulse", int'(take), 0);
        drain();

        // R10: code 2 acts as machine level
        priv = 2'd2; gie = 4'h0; ext_req = 3'b001;
        @(negedge clk);
        chk("R10 masked", int'(take), 0);
        gie = 4'h8;
        @(negedge clk);
        chk("R10 enabled", int'(take), 1);
        drain();
        deleg_m[6] = 1'b1; gie = 4'hF; ext_req = 3'b001;
        @(negedge clk);
        chk("R10 no demote", int'(take), 0);
        drain();

        summary();
    end

endmodule